// File: doc/BRIEF.md
# Receive Frame Slot Manager

This block takes received Ethernet payload bytes from a valid/ready/last byte stream and stores each frame, rebuilt into wire format, in one of several receive buffers that the host has armed. Every buffer slot has a state, a base address and a byte count. The host arms a slot by writing its base address and setting its state to LOADED. The block then fills the lowest-numbered armed slot. In that slot it writes a 7-byte 0x55 preamble, a 0xD5 delimiter, the payload, zero padding up to the Ethernet minimum, and a CRC-32 frame check sequence. When the frame is complete, the slot is marked PENDING, its count is set to the stored size, and an interrupt pulses.

Memory traffic uses a plain one-byte-per-cycle write port. The slot registers are reached through a simple write port and a read port with one cycle of latency, both addressed by slot number and field select. A receive-reset input makes the block take in frames and throw them away.

Top module: `rxslot_mgr`

## Requirements
- R1: Slot fields are written through the host write port and read back on `host_rdata` one cycle after `host_rslot`/`host_rfld` are presented. Field select 0 is the state, 1 is the base address and 2 is the byte count. State codes are EMPTY = 0, LOADED = 1 and PENDING = 2. After reset every field reads 0.
- R2: A frame is placed in the lowest-numbered slot whose state is LOADED.
- R3: While idle, with `rx_reset` low and no slot LOADED, `in_ready` is low, so no byte is taken.
- R4: While `rx_reset` is high, frames are accepted and discarded. There is no memory write, no slot change and no interrupt.
- R5: Bytes base+0 to base+6 hold 0x55 and base+7 holds 0xD5. Payload byte i is stored at base+8+i.
- R6: A payload shorter than 60 bytes is followed by zero bytes up to 60 bytes in total.
- R7: A CRC-32 is computed over the padded payload only. It uses the reflected polynomial 0xEDB88320, starts at 0xFFFFFFFF and is inverted at the end. It is stored directly after the padded payload, least significant byte first.
- R8: When a frame finishes, the slot count becomes padded payload length + 12 and the slot state becomes PENDING. `rx_irq` is then high for exactly one cycle.
- R9: A frame whose stored size would exceed 1530 bytes is dropped. Its slot stays LOADED and no interrupt is raised. A size of exactly 1530 is kept.
- R10: The target slot is fixed when the first payload byte is accepted. Arming a lower-numbered slot while the frame is still arriving does not redirect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_reset | input | 1 | Receive-reset control: accept and discard frames |
| in_valid | input | 1 | Payload byte valid |
| in_data | input | 8 | Payload byte |
| in_last | input | 1 | Last byte of frame |
| in_ready | output | 1 | Block can accept a byte |
| host_we | input | 1 | Slot field write strobe |
| host_wslot | input | SLOT_W | Slot number for write |
| host_wfld | input | 2 | Field select for write |
| host_wdata | input | 32 | Write data |
| host_rslot | input | SLOT_W | Slot number for read |
| host_rfld | input | 2 | Field select for read |
| host_rdata | output | 32 | Registered read data |
| mem_we | output | 1 | Memory byte write strobe |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Memory byte data |
| rx_irq | output | 1 | One-cycle frame-stored pulse |

## Verification
The hardest case to reach from the ports is a host write that lands while a frame is only partly received. The bench runs the stream task and a delayed host write in parallel branches. That write arms a lower slot several bytes into the frame, and the bench then checks that the frame stays in the slot chosen at its first byte. The size limit is tested on both sides of the boundary with payloads of 1518 and 1519 bytes. After the dropped frame, the slot must still read LOADED with no interrupt seen.

// File: rtl/rxslot_pkg.sv
package rxslot_pkg;
  typedef enum logic [1:0] {
    SLOT_EMPTY   = 2'd0,
    SLOT_LOADED  = 2'd1,
    SLOT_PENDING = 2'd2
  } slot_state_e;

  localparam logic [1:0] FLD_STATE = 2'd0;
  localparam logic [1:0] FLD_BASE  = 2'd1;
  localparam logic [1:0] FLD_COUNT = 2'd2;

  typedef enum logic [2:0] {
    W_IDLE, W_RECV, W_DISC, W_PAD, W_FCS, W_PRE, W_DONE
  } wr_state_e;

  localparam logic [31:0] CRC_POLY = 32'hEDB88320;
  localparam logic [7:0]  PRE_BYTE = 8'h55;
  localparam logic [7:0]  SFD_BYTE = 8'hD5;

  // one byte through a reflected CRC-32, LSB first
  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'h0, d};
    for (int b = 0; b < 8; b++)
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    return r;
  endfunction
endpackage

// File: rtl/rxslot_crc.sv
module rxslot_crc (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] fcs
);
  import rxslot_pkg::*;
  logic [31:0] acc_q;

  always_ff @(posedge clk) begin
    if (rst)
      acc_q <= '1;
    else if (en)
      acc_q <= crc_byte(start ? 32'hFFFF_FFFF : acc_q, din);
  end

  assign fcs = ~acc_q;
endmodule

// File: rtl/rxslot_regs.sv
module rxslot_regs #(
  parameter int NSLOT  = 4,
  parameter int SLOT_W = 2,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic [SLOT_W-1:0] host_wslot,
  input  logic [1:0]        host_wfld,
  input  logic [31:0]       host_wdata,
  input  logic [SLOT_W-1:0] host_rslot,
  input  logic [1:0]        host_rfld,
  output logic [31:0]       host_rdata,
  input  logic              cmpl_en,
  input  logic [SLOT_W-1:0] cmpl_slot,
  input  logic [CNT_W-1:0]  cmpl_count,
  input  logic [SLOT_W-1:0] pick_idx,
  output logic [ADDR_W-1:0] pick_base,
  output logic [NSLOT-1:0]  loaded_vec
);
  import rxslot_pkg::*;

  logic [1:0]        st_q   [NSLOT];
  logic [ADDR_W-1:0] base_q [NSLOT];
  logic [CNT_W-1:0]  cnt_q  [NSLOT];

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic hit_w, hit_c;
    assign hit_w = host_we && (host_wslot == SLOT_W'(s));
    assign hit_c = cmpl_en && (cmpl_slot == SLOT_W'(s));

    always_ff @(posedge clk) begin
      if (rst) begin
        st_q[s]   <= SLOT_EMPTY;
        base_q[s] <= '0;
        cnt_q[s]  <= '0;
      end else if (hit_c) begin
        // completion wins over a host write in the same cycle
        st_q[s]  <= SLOT_PENDING;
        cnt_q[s] <= cmpl_count;
      end else if (hit_w) begin
        case (host_wfld)
          FLD_STATE: st_q[s]   <= host_wdata[1:0];
          FLD_BASE:  base_q[s] <= host_wdata[ADDR_W-1:0];
          FLD_COUNT: cnt_q[s]  <= host_wdata[CNT_W-1:0];
          default: ;
        endcase
      end
    end

    assign loaded_vec[s] = (st_q[s] == SLOT_LOADED);
  end

  assign pick_base = base_q[pick_idx];

  always_ff @(posedge clk) begin
    if (rst)
      host_rdata <= '0;
    else begin
      case (host_rfld)
        FLD_STATE: host_rdata <= {30'h0, st_q[host_rslot]};
        FLD_BASE:  host_rdata <= 32'(base_q[host_rslot]);
        FLD_COUNT: host_rdata <= 32'(cnt_q[host_rslot]);
        default:   host_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/rxslot_writer.sv
module rxslot_writer #(
  parameter int NSLOT     = 4,
  parameter int SLOT_W    = 2,
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 16,
  parameter int MIN_PAY   = 60,
  parameter int MAX_FRAME = 1530
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_reset,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  output logic              in_ready,
  input  logic [NSLOT-1:0]  loaded_vec,
  output logic [SLOT_W-1:0] pick_idx,
  input  logic [ADDR_W-1:0] pick_base,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              cmpl_en,
  output logic [SLOT_W-1:0] cmpl_slot,
  output logic [CNT_W-1:0]  cmpl_count,
  output logic              wr_idle
);
  import rxslot_pkg::*;

  localparam int MAX_PAY = MAX_FRAME - 12;
  localparam int PAY_W   = $clog2(MAX_PAY + 2);
  localparam int HDR     = 8;

  wr_state_e         st_q;
  logic [PAY_W-1:0]  cnt_q;
  logic [2:0]        k_q;
  logic              ovf_q;
  logic [ADDR_W-1:0] base_q;
  logic [SLOT_W-1:0] slot_q;
  logic              pick_ok;
  logic              fire;
  logic              crc_start, crc_en;
  logic [7:0]        crc_din;
  logic [31:0]       fcs;
  logic [ADDR_W-1:0] pay_ptr;

  // lowest-numbered LOADED slot
  always_comb begin
    pick_ok  = 1'b0;
    pick_idx = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (loaded_vec[i]) begin
        pick_ok  = 1'b1;
        pick_idx = SLOT_W'(i);
      end
    end
  end

  always_comb begin
    case (st_q)
      W_IDLE:         in_ready = rx_reset || pick_ok;
      W_RECV, W_DISC: in_ready = 1'b1;
      default:        in_ready = 1'b0;
    endcase
  end

  assign fire    = in_valid && in_ready;
  assign wr_idle = (st_q == W_IDLE);
  assign pay_ptr = base_q + ADDR_W'(HDR) + ADDR_W'(cnt_q);

  always_comb begin
    crc_start = (st_q == W_IDLE);
    crc_din   = (st_q == W_PAD) ? 8'h00 : in_data;
    case (st_q)
      W_IDLE:  crc_en = fire && !rx_reset;
      W_RECV:  crc_en = fire && !ovf_q && (cnt_q < PAY_W'(MAX_PAY));
      W_PAD:   crc_en = 1'b1;
      default: crc_en = 1'b0;
    endcase
  end

  rxslot_crc crc_i (
    .clk(clk), .rst(rst), .start(crc_start), .en(crc_en), .din(crc_din), .fcs(fcs)
  );

  assign cmpl_en    = (st_q == W_DONE);
  assign cmpl_slot  = slot_q;
  assign cmpl_count = CNT_W'(cnt_q) + CNT_W'(12);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= W_IDLE;
      cnt_q     <= '0;
      k_q       <= '0;
      ovf_q     <= 1'b0;
      base_q    <= '0;
      slot_q    <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      case (st_q)
        W_IDLE: if (fire) begin
          if (rx_reset) begin
            st_q <= in_last ? W_IDLE : W_DISC;
          end else begin
            slot_q    <= pick_idx;
            base_q    <= pick_base;
            cnt_q     <= PAY_W'(1);
            ovf_q     <= 1'b0;
            k_q       <= '0;
            mem_we    <= 1'b1;
            mem_addr  <= pick_base + ADDR_W'(HDR);
            mem_wdata <= in_data;
            if (in_last) st_q <= (MIN_PAY > 1) ? W_PAD : W_FCS;
            else         st_q <= W_RECV;
          end
        end
        W_DISC: if (fire && in_last) st_q <= W_IDLE;
        W_RECV: if (fire) begin
          if (cnt_q >= PAY_W'(MAX_PAY)) begin
            ovf_q <= 1'b1;
          end else begin
            mem_we    <= 1'b1;
            mem_addr  <= pay_ptr;
            mem_wdata <= in_data;
            cnt_q     <= cnt_q + 1'b1;
          end
          if (in_last) begin
            if (ovf_q || cnt_q >= PAY_W'(MAX_PAY)) st_q <= W_IDLE;
            else if (cnt_q + 1'b1 < PAY_W'(MIN_PAY)) st_q <= W_PAD;
            else st_q <= W_FCS;
          end
        end
        W_PAD: begin
          mem_we    <= 1'b1;
          mem_addr  <= pay_ptr;
          mem_wdata <= 8'h00;
          cnt_q     <= cnt_q + 1'b1;
          if (cnt_q + 1'b1 >= PAY_W'(MIN_PAY)) st_q <= W_FCS;
        end
        W_FCS: begin
          mem_we   <= 1'b1;
          mem_addr <= pay_ptr + ADDR_W'(k_q);
          case (k_q[1:0])
            2'd0: mem_wdata <= fcs[7:0];
            2'd1: mem_wdata <= fcs[15:8];
            2'd2: mem_wdata <= fcs[23:16];
            default: mem_wdata <= fcs[31:24];
          endcase
          if (k_q == 3'd3) begin
            k_q  <= '0;
            cnt_q <= cnt_q; 
            st_q <= W_PRE;
          end else begin
            k_q <= k_q + 1'b1;
          end
        end
        W_PRE: begin
          mem_we    <= 1'b1;
          mem_addr  <= base_q + ADDR_W'(k_q);
          mem_wdata <= (k_q == 3'd7) ? SFD_BYTE : PRE_BYTE;
          k_q       <= k_q + 1'b1;
          if (k_q == 3'd7) st_q <= W_DONE;
        end
        W_DONE: st_q <= W_IDLE;
        default: st_q <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxslot_mgr.sv
module rxslot_mgr #(
  parameter int NSLOT     = 4,
  parameter int SLOT_W    = $clog2(NSLOT),
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 16,
  parameter int MIN_PAY   = 60,
  parameter int MAX_FRAME = 1530
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_reset,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  output logic              in_ready,
  input  logic              host_we,
  input  logic [SLOT_W-1:0] host_wslot,
  input  logic [1:0]        host_wfld,
  input  logic [31:0]       host_wdata,
  input  logic [SLOT_W-1:0] host_rslot,
  input  logic [1:0]        host_rfld,
  output logic [31:0]       host_rdata,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              rx_irq
);
  logic [NSLOT-1:0]  loaded_vec;
  logic [SLOT_W-1:0] pick_idx;
  logic [ADDR_W-1:0] pick_base;
  logic              cmpl_en;
  logic [SLOT_W-1:0] cmpl_slot;
  logic [CNT_W-1:0]  cmpl_count;
  logic              wr_idle;

  rxslot_regs #(
    .NSLOT(NSLOT), .SLOT_W(SLOT_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) regs_i (
    .clk(clk), .rst(rst),
    .host_we(host_we), .host_wslot(host_wslot), .host_wfld(host_wfld), .host_wdata(host_wdata),
    .host_rslot(host_rslot), .host_rfld(host_rfld), .host_rdata(host_rdata),
    .cmpl_en(cmpl_en), .cmpl_slot(cmpl_slot), .cmpl_count(cmpl_count),
    .pick_idx(pick_idx), .pick_base(pick_base), .loaded_vec(loaded_vec)
  );

  rxslot_writer #(
    .NSLOT(NSLOT), .SLOT_W(SLOT_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
    .MIN_PAY(MIN_PAY), .MAX_FRAME(MAX_FRAME)
  ) wr_i (
    .clk(clk), .rst(rst), .rx_reset(rx_reset),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .loaded_vec(loaded_vec), .pick_idx(pick_idx), .pick_base(pick_base),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .cmpl_en(cmpl_en), .cmpl_slot(cmpl_slot), .cmpl_count(cmpl_count),
    .wr_idle(wr_idle)
  );

  always_ff @(posedge clk) begin
    if (rst) rx_irq <= 1'b0;
    else     rx_irq <= cmpl_en;
  end
endmodule

// File: rtl/rxslot_mgr_chk.sv
module rxslot_mgr_chk #(
  parameter int NSLOT  = 4,
  parameter int SLOT_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_reset,
  input logic              in_valid,
  input logic              in_ready,
  input logic              mem_we,
  input logic              rx_irq,
  input logic              wr_idle,
  input logic              cmpl_en,
  input logic [SLOT_W-1:0] cmpl_slot,
  input logic [NSLOT-1:0]  loaded_vec
);
  // R8: interrupt lasts one cycle
  p_irq_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    rx_irq |=> !rx_irq);

  // R8: completion leaves the slot no longer LOADED and raises the interrupt
  p_pending_r8: assert property (@(posedge clk) disable iff (rst)
    cmpl_en |=> (rx_irq && !loaded_vec[$past(cmpl_slot)]));

  // R3: nothing armed, not in receive reset, idle -> no byte lands in memory
  p_stall_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_idle && !rx_reset && (loaded_vec == '0)) |=> !mem_we);

  // R4: a byte taken under receive reset is never written
  p_discard_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_idle && rx_reset && in_valid && in_ready) |=> !mem_we);

  // R10: target slot does not move while a frame is in flight
  p_slot_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!wr_idle && !$past(wr_idle)) |-> $stable(cmpl_slot));
endmodule

bind rxslot_mgr rxslot_mgr_chk #(.NSLOT(NSLOT), .SLOT_W(SLOT_W)) chk_i (
  .clk(clk), .rst(rst), .rx_reset(rx_reset), .in_valid(in_valid), .in_ready(in_ready),
  .mem_we(mem_we), .rx_irq(rx_irq), .wr_idle(wr_idle), .cmpl_en(cmpl_en),
  .cmpl_slot(cmpl_slot), .loaded_vec(loaded_vec)
);

// File: tb/rxslot_mgr_tb_top.sv
`timescale 1ns/1ps
module rxslot_mgr_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_reset = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_last = 1'b0;
  logic        in_ready;
  logic        host_we = 1'b0;
  logic [1:0]  host_wslot = '0;
  logic [1:0]  host_wfld = '0;
  logic [31:0] host_wdata = '0;
  logic [1:0]  host_rslot = '0;
  logic [1:0]  host_rfld = '0;
  logic [31:0] host_rdata;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        rx_irq;

  int vec_cnt = 0, bad_cnt = 0, irq_hi = 0, wr_cnt = 0;
  logic [7:0] bmem [0:8191];
  logic [7:0] pay  [0:1599];

  always #2.5 clk = ~clk;

  rxslot_mgr dut_i (
    .clk(clk), .rst(rst), .rx_reset(rx_reset),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .host_we(host_we), .host_wslot(host_wslot), .host_wfld(host_wfld), .host_wdata(host_wdata),
    .host_rslot(host_rslot), .host_rfld(host_rfld), .host_rdata(host_rdata),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .rx_irq(rx_irq)
  );

  always @(posedge clk) begin
    if (mem_we) begin
      bmem[mem_addr[12:0]] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    if (rx_irq) irq_hi <= irq_hi + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vec_cnt++;
    if (!ok) begin
      bad_cnt++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ {24'h0, pay[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic host_write(input int slot, input int fld, input int data);
    @(negedge clk);
    host_we = 1'b1; host_wslot = 2'(slot); host_wfld = 2'(fld); host_wdata = data;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic host_read(input int slot, input int fld, output int data);
    @(negedge clk);
    host_rslot = 2'(slot); host_rfld = 2'(fld);
    @(posedge clk); #1;
    data = host_rdata;
  endtask

  task automatic fill_pay(input int n, input int seed);
    for (int i = 0; i < 1600; i++) pay[i] = 8'((i < n) ? (i * seed + 3) : 0);
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 8192; i++) bmem[i] = 8'hEE;
  endtask

  task automatic send_frame(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = pay[i]; in_last = (i == n - 1);
      #1;
      while (!in_ready) begin @(negedge clk); #1; end
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    repeat (100) @(negedge clk);
  endtask

  // checks layout, padding, CRC, count, state
  task automatic check_frame(input int slot, input int n);
    int base = slot * 2048;
    int padded = (n < 60) ? 60 : n;
    logic [31:0] c = 0;
    int v;
    int bad_pre = 0, bad_pay = 0, bad_pad = 0;
    for (int i = 0; i < 7; i++) if (bmem[base + i] !== 8'h55) bad_pre++;
    if (bmem[base + 7] !== 8'hD5) bad_pre++;
    check(bad_pre == 0, "R5 preamble", bad_pre, 0);
    for (int i = 0; i < n; i++) if (bmem[base + 8 + i] !== pay[i]) bad_pay++;
    check(bad_pay == 0, "R5 payload", bad_pay, 0);
    for (int i = n; i < padded; i++) if (bmem[base + 8 + i] !== 8'h00) bad_pad++;
    check(bad_pad == 0, "R6 padding", bad_pad, 0);
    for (int i = 0; i < 4; i++) c[8*i +: 8] = bmem[base + 8 + padded + i];
    check(c == ref_crc(padded), "R7 fcs", c, ref_crc(padded));
    host_read(slot, 2, v);
    check(v == padded + 12, "R8 count", v, padded + 12);
    host_read(slot, 0, v);
    check(v == 2, "R8 state", v, 2);
  endtask

  task automatic t_reset();
    int v;
    check(rx_irq == 0 && mem_we == 0, "R1 reset outputs", {rx_irq, mem_we}, 0);
    host_read(2, 0, v); check(v == 0, "R1 reset state", v, 0);
    host_read(3, 1, v); check(v == 0, "R1 reset base", v, 0);
  endtask

  task automatic t_host_rw();
    int v;
    for (int s = 0; s < 4; s++) host_write(s, 1, s * 2048);
    host_read(3, 1, v); check(v == 6144, "R1 base readback", v, 6144);
    host_write(1, 2, 32'h1234);
    host_read(1, 2, v); check(v == 32'h1234, "R1 count readback", v, 32'h1234);
  endtask

  task automatic t_stall();
    int w0 = wr_cnt;
    @(negedge clk); #1;
    check(in_ready == 0, "R3 ready low", in_ready, 0);
    repeat (5) @(negedge clk);
    check(wr_cnt == w0, "R3 no writes", wr_cnt - w0, 0);
  endtask

  task automatic t_short();
    int i0 = irq_hi;
    clear_mem(); fill_pay(10, 7);
    host_write(0, 0, 1);
    send_frame(10);
    check_frame(0, 10);
    check(irq_hi - i0 == 1, "R8 irq one cycle", irq_hi - i0, 1);
  endtask

  task automatic t_priority();
    int v;
    clear_mem(); fill_pay(64, 5);
    host_write(0, 0, 0); host_write(1, 0, 1); host_write(3, 0, 1);
    send_frame(64);
    check_frame(1, 64);
    host_read(3, 0, v); check(v == 1, "R2 higher slot untouched", v, 1);
  endtask

  task automatic t_exact60();
    clear_mem(); fill_pay(60, 11);
    send_frame(60);
    check_frame(3, 60);
  endtask

  task automatic t_rxreset();
    int v, w0, i0;
    host_write(0, 0, 1);
    w0 = wr_cnt; i0 = irq_hi;
    rx_reset = 1'b1;
    fill_pay(20, 3);
    send_frame(20);
    rx_reset = 1'b0;
    check(wr_cnt == w0, "R4 no writes", wr_cnt - w0, 0);
    check(irq_hi == i0, "R4 no irq", irq_hi - i0, 0);
    host_read(0, 0, v); check(v == 1, "R4 slot unchanged", v, 1);
  endtask

  task automatic t_latch();
    int v;
    clear_mem(); fill_pay(20, 9);
    host_write(0, 0, 0); host_write(2, 0, 1);
    fork
      send_frame(20);
      begin repeat (6) @(negedge clk); host_write(0, 0, 1); end
    join
    check_frame(2, 20);
    host_read(0, 0, v); check(v == 1, "R10 lower slot still armed", v, 1);
  endtask

  task automatic t_size();
    int v, i0;
    host_write(0, 0, 0); host_write(1, 0, 1);
    i0 = irq_hi;
    fill_pay(1519, 13);
    send_frame(1519);
    host_read(1, 0, v); check(v == 1, "R9 oversize slot stays LOADED", v, 1);
    check(irq_hi == i0, "R9 oversize no irq", irq_hi - i0, 0);
    clear_mem(); fill_pay(1518, 17);
    send_frame(1518);
    check_frame(1, 1518);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_host_rw();
    t_stall();
    t_short();
    t_priority();
    t_exact60();
    t_rxreset();
    t_latch();
    t_size();
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    vec_cnt++; bad_cnt++;
    $display("FAIL watchdog: actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
    $finish;
  end
endmodule